// File: doc/BRIEF.md
# Deferred-Fault Tracker for Speculative Loads

This block keeps the bookkeeping that lets a processor run loads speculatively without taking a fault at the point of issue. When a speculative load is misaligned in memory, or names a misaligned register group, the block marks its destination register as poisoned instead of trapping. Poison also spreads: a clean load whose base register or displacement register is poisoned poisons its own destination and is told not to access memory. Two poison vectors are held, one for the integer register file and one for the floating-point file. Each vector is split into a low half and a high half, and that split is what the "all registers" commit works on.

When its control register enables logging, every speculative load also claims a slot in a small table of deferred-fault records. A record holds the target, the size, the bank, the slot's own number, the effective address and two error codes. A later commit operation on a register, or on the whole bank, turns pending poison into a precise commit exception. It also wipes the matching records. A clear-only operation does the same wiping and never raises the exception. The address adder and the load datapath live outside this block. Loads and commits are presented one at a time, at most one per cycle.

Top module: `ne_defer_tracker`

## Requirements
- R1: A speculative load (`ld_req`) with size code 0 (byte) never faults in memory. Size 1 (half) faults when address bit 0 is set, size 2 (word) when `addr & 3` is nonzero, size 3 (double) when `addr & 7` is nonzero, and size 4 (quad) when `addr & 15` is nonzero. Codes 5 to 7 behave as byte. A fault sets the target's poison flag, and `ld_go` stays 1.
- R2: A double load with an odd target index, or a quad load whose target index has either of its two low bits set, is a register-alignment fault. This fault also sets the target flag, and `ld_go` stays 1.
- R3: With no fault, a load whose base register flag is set, or whose displacement register flag is set while `ld_disp_use`=1, sets its target flag and drives `ld_go`=0 in that same cycle.
- R4: With no fault and clean sources, the load clears its target flag and drives `ld_go`=1. The displacement register flag is ignored when `ld_disp_use`=0. When `ld_req`=0, `ld_go` is 0.
- R5: Logging is active when the control register has valid=1 and log-enable=1. Every load then claims the lowest-numbered free slot below the programmed slot count. The slot records valid=1, address-valid=1, bank, size code, target, its own slot number, the address, the memory-fault code (`rd_mem_err`) and the register-fault code (`rd_reg_err`).
- R6: When logging is active and no free slot exists below the count, `ovf_err` is 1 for exactly the cycle after the load. The flag update of R1 to R4 still takes place.
- R7: A commit (`cm_req`, `cm_clear_only`=0) on one target reads that target's flag and then clears it. If the flag was set and logging is active, `cm_exc` is 1 for the cycle after the commit.
- R8: A commit with `cm_all`=1 counts as pending when any set flag lies in a half marked available. The high half is indices NREG/2 and up. Only the available halves are cleared.
- R9: On a pending commit with logging active, every valid slot of the same bank is zeroed, provided its target matches or `cm_all`=1. Slots of the other bank remain valid. A commit that is not pending leaves the slots unchanged.
- R10: A clear-only operation clears the same flags and, when logging is active, the same slots regardless of pending poison. It never raises `cm_exc`.
- R11: With logging inactive, a commit on a poisoned target raises no exception and leaves the slots untouched, but it still clears the flag.
- R12: A single-target commit or clear whose target lies in a half marked unavailable has no effect.
- R13: After reset all flags are clear, all slots are invalid, logging is off, and `cm_exc`, `ovf_err` and `ld_go` are 0.
- R14: Loads and commits act only on the bank chosen by their FP select. The other bank's flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write the control register |
| cfg_valid | input | 1 | Control register valid bit |
| cfg_log_en | input | 1 | Enable fault logging |
| cfg_count | input | NW | Number of slots usable for logging |
| ld_req | input | 1 | Speculative load present |
| ld_fp | input | 1 | Target and sources are in the FP bank |
| ld_base_idx | input | IDXW | Base register index |
| ld_disp_use | input | 1 | Displacement comes from a register |
| ld_disp_idx | input | IDXW | Displacement register index |
| ld_addr | input | AW | Effective address |
| ld_size | input | 3 | Size code (0 byte, 1 half, 2 word, 3 double, 4 quad) |
| ld_tgt | input | IDXW | Target register index |
| ld_go | output | 1 | Perform the memory access |
| cm_req | input | 1 | Commit or clear operation present |
| cm_clear_only | input | 1 | Clear without exception |
| cm_fp | input | 1 | Bank select |
| cm_all | input | 1 | Act on all registers instead of `cm_tgt` |
| cm_tgt | input | IDXW | Target register index |
| cm_hi_avail | input | 1 | High half of the bank is available |
| cm_lo_avail | input | 1 | Low half of the bank is available |
| cm_exc | output | 1 | Commit exception, one cycle after the commit |
| ovf_err | output | 1 | No free slot, one cycle after the load |
| fq_fp | input | 1 | Flag query bank |
| fq_idx | input | IDXW | Flag query index |
| fq_flag | output | 1 | Queried poison flag |
| rd_idx | input | EW | Slot read index |
| rd_valid | output | 1 | Slot valid |
| rd_eav | output | 1 | Slot address valid |
| rd_fp | output | 1 | Slot bank |
| rd_size | output | 3 | Slot size code |
| rd_tgt | output | IDXW | Slot target |
| rd_slot | output | EW | Slot's own number |
| rd_mem_err | output | 1 | Memory-misalignment code |
| rd_reg_err | output | 1 | Register-misalignment code |
| rd_addr | output | AW | Slot address |

## Verification
A wrong flag bit is visible in the next cycle, through the flag query or through `ld_go` of a later load that uses the register as a source. A stale or wrongly placed slot shows at the slot read port right after the operation. It also shows on the next load's choice of slot, or as an early or missing `ovf_err`. A commit that clears too much or too little shows as a missing or spurious `cm_exc` one cycle after the commit, and as flags in the other half or bank changing.

// File: rtl/ne_defer_pkg.sv
package ne_defer_pkg;
   typedef enum logic [2:0] {
      SZ_BYTE = 3'd0,
      SZ_HALF = 3'd1,
      SZ_WORD = 3'd2,
      SZ_DBL  = 3'd3,
      SZ_QUAD = 3'd4
   } ne_size_e;
endpackage

// File: rtl/ne_align_chk.sv
module ne_align_chk
   import ne_defer_pkg::*;
#(
   parameter int IDXW = 6
) (
   input  logic [2:0]      size,
   input  logic [3:0]      addr_lo,
   input  logic [IDXW-1:0] tgt,
   output logic            mem_err,
   output logic            reg_err
);
   always_comb begin
      mem_err = 1'b0;
      reg_err = 1'b0;
      case (size)
         SZ_HALF: mem_err = addr_lo[0];
         SZ_WORD: mem_err = |addr_lo[1:0];
         SZ_DBL: begin
            mem_err = |addr_lo[2:0];
            reg_err = tgt[0];
         end
         SZ_QUAD: begin
            mem_err = |addr_lo;
            reg_err = |tgt[1:0];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/ne_flag_bank.sv
module ne_flag_bank #(
   parameter int NREG = 64,
   localparam int IDXW = $clog2(NREG),
   localparam int HALF = NREG / 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [IDXW-1:0] wr_idx,
   input  logic            wr_val,
   input  logic            wipe_hi,
   input  logic            wipe_lo,
   output logic [NREG-1:0] q
);
   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [HALF-1:0] r;
      wire             wipe = (h == 1) ? wipe_hi : wipe_lo;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r <= '0;
         end else if (wipe) begin
            r <= '0;
         end else if (wr_en && (wr_idx[IDXW-1] == h[0])) begin
            r[wr_idx[IDXW-2:0]] <= wr_val;
         end
      end
      assign q[h*HALF +: HALF] = r;
   end
endmodule

// File: rtl/ne_entry_file.sv
module ne_entry_file #(
   parameter int NENT = 8,
   parameter int IDXW = 6,
   parameter int AW   = 32,
   localparam int EW  = $clog2(NENT),
   localparam int NW  = $clog2(NENT + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alloc_req,
   input  logic [NW-1:0]   nen,
   input  logic            a_fp,
   input  logic [2:0]      a_size,
   input  logic [IDXW-1:0] a_tgt,
   input  logic [AW-1:0]   a_addr,
   input  logic            a_mem_err,
   input  logic            a_reg_err,
   output logic            alloc_fail,
   input  logic            clr_req,
   input  logic            clr_fp,
   input  logic            clr_all,
   input  logic [IDXW-1:0] clr_tgt,
   input  logic [EW-1:0]   rd_idx,
   output logic            rd_valid,
   output logic            rd_eav,
   output logic            rd_fp,
   output logic [2:0]      rd_size,
   output logic [IDXW-1:0] rd_tgt,
   output logic [EW-1:0]   rd_slot,
   output logic            rd_mem_err,
   output logic            rd_reg_err,
   output logic [AW-1:0]   rd_addr
);
   typedef struct packed {
      logic            valid;
      logic            eav;
      logic            fp;
      logic [2:0]      size;
      logic [IDXW-1:0] tgt;
      logic [EW-1:0]   slot;
      logic            mem_err;
      logic            reg_err;
      logic [AW-1:0]   addr;
   } slot_t;

   slot_t           ent [NENT];
   logic [NENT-1:0] grant;
   logic [NENT-1:0] vvec;

   always_comb begin
      logic found;
      found = 1'b0;
      grant = '0;
      for (int i = 0; i < NENT; i++) begin
         if (!found && (NW'(i) < nen) && !ent[i].valid) begin
            grant[i] = 1'b1;
            found    = 1'b1;
         end
      end
      alloc_fail = !found;
   end

   for (genvar i = 0; i < NENT; i++) begin : g_ent
      wire kill = clr_req && ent[i].valid && (ent[i].fp == clr_fp) &&
                  (clr_all || (ent[i].tgt == clr_tgt));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent[i] <= '0;
         end else if (alloc_req && grant[i]) begin
            ent[i] <= '{valid: 1'b1, eav: 1'b1, fp: a_fp, size: a_size,
                        tgt: a_tgt, slot: EW'(i), mem_err: a_mem_err,
                        reg_err: a_reg_err, addr: a_addr};
         end else if (kill) begin
            ent[i] <= '0;
         end
      end
      assign vvec[i] = ent[i].valid;

      AST_SLOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
         ent[i].valid |-> (ent[i].slot == EW'(i)));  // R5
   end

   AST_ALLOC_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_req && !alloc_fail && !clr_req) |=>
         ($countones(vvec) == $past($countones(vvec)) + 1));  // R5

   always_comb begin
      rd_valid   = ent[rd_idx].valid;
      rd_eav     = ent[rd_idx].eav;
      rd_fp      = ent[rd_idx].fp;
      rd_size    = ent[rd_idx].size;
      rd_tgt     = ent[rd_idx].tgt;
      rd_slot    = ent[rd_idx].slot;
      rd_mem_err = ent[rd_idx].mem_err;
      rd_reg_err = ent[rd_idx].reg_err;
      rd_addr    = ent[rd_idx].addr;
   end
endmodule

// File: rtl/ne_defer_tracker.sv
module ne_defer_tracker #(
   parameter int NREG = 64,
   parameter int NENT = 8,
   parameter int AW   = 32,
   localparam int IDXW = $clog2(NREG),
   localparam int EW   = $clog2(NENT),
   localparam int NW   = $clog2(NENT + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic            cfg_valid,
   input  logic            cfg_log_en,
   input  logic [NW-1:0]   cfg_count,
   input  logic            ld_req,
   input  logic            ld_fp,
   input  logic [IDXW-1:0] ld_base_idx,
   input  logic            ld_disp_use,
   input  logic [IDXW-1:0] ld_disp_idx,
   input  logic [AW-1:0]   ld_addr,
   input  logic [2:0]      ld_size,
   input  logic [IDXW-1:0] ld_tgt,
   output logic            ld_go,
   input  logic            cm_req,
   input  logic            cm_clear_only,
   input  logic            cm_fp,
   input  logic            cm_all,
   input  logic [IDXW-1:0] cm_tgt,
   input  logic            cm_hi_avail,
   input  logic            cm_lo_avail,
   output logic            cm_exc,
   output logic            ovf_err,
   input  logic            fq_fp,
   input  logic [IDXW-1:0] fq_idx,
   output logic            fq_flag,
   input  logic [EW-1:0]   rd_idx,
   output logic            rd_valid,
   output logic            rd_eav,
   output logic            rd_fp,
   output logic [2:0]      rd_size,
   output logic [IDXW-1:0] rd_tgt,
   output logic [EW-1:0]   rd_slot,
   output logic            rd_mem_err,
   output logic            rd_reg_err,
   output logic [AW-1:0]   rd_addr
);
   localparam int HALF = NREG / 2;

   if (NREG < 4 || (1 << IDXW) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two, at least 4");
   end
   if (NENT < 2 || (1 << EW) != NENT) begin : g_bad_nent
      $error("NENT must be a power of two, at least 2");
   end
   if (AW < 4) begin : g_bad_aw
      $error("AW must be at least 4");
   end

   // control register
   logic          ctl_valid, ctl_log;
   logic [NW-1:0] ctl_count;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_valid <= 1'b0;
         ctl_log   <= 1'b0;
         ctl_count <= '0;
      end else if (cfg_we) begin
         ctl_valid <= cfg_valid;
         ctl_log   <= cfg_log_en;
         ctl_count <= cfg_count;
      end
   end
   wire logging = ctl_valid && ctl_log;

   // alignment
   logic mem_err, reg_err;
   ne_align_chk #(.IDXW(IDXW)) u_align (
      .size(ld_size), .addr_lo(ld_addr[3:0]), .tgt(ld_tgt),
      .mem_err(mem_err), .reg_err(reg_err)
   );

   // poison banks
   logic [NREG-1:0] bank_q [2];
   wire  fault    = mem_err || reg_err;
   wire  src_flag = bank_q[ld_fp][ld_base_idx] ||
                    (ld_disp_use && bank_q[ld_fp][ld_disp_idx]);
   assign ld_go   = ld_req && (fault || !src_flag);

   wire tgt_hi  = cm_tgt[IDXW-1];
   wire cm_ok   = cm_all || (tgt_hi ? cm_hi_avail : cm_lo_avail);
   wire [NREG-1:0] cmq = bank_q[cm_fp];
   wire pending = cm_all ?
                  ((cm_hi_avail && |cmq[NREG-1:HALF]) ||
                   (cm_lo_avail && |cmq[HALF-1:0])) :
                  (cm_ok && cmq[cm_tgt]);

   for (genvar b = 0; b < 2; b++) begin : g_bank
      wire ld_here = ld_req && (ld_fp == b[0]);
      wire cm_here = cm_req && (cm_fp == b[0]);
      ne_flag_bank #(.NREG(NREG)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .wr_en(ld_here || (cm_here && !cm_all && cm_ok)),
         .wr_idx(ld_here ? ld_tgt : cm_tgt),
         .wr_val(ld_here && (fault || src_flag)),
         .wipe_hi(cm_here && cm_all && cm_hi_avail),
         .wipe_lo(cm_here && cm_all && cm_lo_avail),
         .q(bank_q[b])
      );
   end

   // record table
   logic alloc_fail;
   wire  clr_req = cm_req && cm_ok && logging && (cm_clear_only || pending);
   ne_entry_file #(.NENT(NENT), .IDXW(IDXW), .AW(AW)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .alloc_req(ld_req && logging), .nen(ctl_count),
      .a_fp(ld_fp), .a_size(ld_size), .a_tgt(ld_tgt), .a_addr(ld_addr),
      .a_mem_err(mem_err), .a_reg_err(reg_err), .alloc_fail(alloc_fail),
      .clr_req(clr_req), .clr_fp(cm_fp), .clr_all(cm_all), .clr_tgt(cm_tgt),
      .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_eav(rd_eav), .rd_fp(rd_fp),
      .rd_size(rd_size), .rd_tgt(rd_tgt), .rd_slot(rd_slot),
      .rd_mem_err(rd_mem_err), .rd_reg_err(rd_reg_err), .rd_addr(rd_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cm_exc  <= 1'b0;
         ovf_err <= 1'b0;
      end else begin
         cm_exc  <= cm_req && !cm_clear_only && logging && pending;
         ovf_err <= ld_req && logging && alloc_fail;
      end
   end

   assign fq_flag = bank_q[fq_fp][fq_idx];

   AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_req && cm_req));  // R14
   AST_LOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req |=> (bank_q[$past(ld_fp)][$past(ld_tgt)] ==
                  $past(mem_err || reg_err || !ld_go)));  // R3
   AST_COMMIT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_req && cm_ok && !cm_all) |=>
         !bank_q[$past(cm_fp)][$past(cm_tgt)]);  // R7
   AST_NO_CLR_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      cm_exc |-> ($past(cm_req) && !$past(cm_clear_only)));  // R10
   AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |-> $past(ld_req));  // R6
endmodule

// File: tb/tb_ne_defer_tracker.sv
`timescale 1ns/1ps
module tb_ne_defer_tracker;
   localparam int NREG = 64, NENT = 8, AW = 32;
   localparam int IDXW = 6, EW = 3, NW = 4;

   logic clk = 0, rst_n = 0;
   always #4 clk = ~clk;

   logic cfg_we = 0, cfg_valid = 0, cfg_log_en = 0;
   logic [NW-1:0] cfg_count = 0;
   logic ld_req = 0, ld_fp = 0, ld_disp_use = 0;
   logic [IDXW-1:0] ld_base_idx = 0, ld_disp_idx = 0, ld_tgt = 0;
   logic [AW-1:0] ld_addr = 0;
   logic [2:0] ld_size = 0;
   logic ld_go;
   logic cm_req = 0, cm_clear_only = 0, cm_fp = 0, cm_all = 0;
   logic cm_hi_avail = 1, cm_lo_avail = 1;
   logic [IDXW-1:0] cm_tgt = 0;
   logic cm_exc, ovf_err;
   logic fq_fp = 0;
   logic [IDXW-1:0] fq_idx = 0;
   logic fq_flag;
   logic [EW-1:0] rd_idx = 0;
   logic rd_valid, rd_eav, rd_fp, rd_mem_err, rd_reg_err;
   logic [2:0] rd_size;
   logic [IDXW-1:0] rd_tgt;
   logic [EW-1:0] rd_slot;
   logic [AW-1:0] rd_addr;

   ne_defer_tracker #(.NREG(NREG), .NENT(NENT), .AW(AW)) dut (.*);

   int tests = 0, fails = 0;
   bit done = 0;
   logic last_go, last_ovf, last_exc;

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit exp_mis(int sz, int a);
      case (sz)
         1: return (a & 1) != 0;
         2: return (a & 3) != 0;
         3: return (a & 7) != 0;
         4: return (a & 15) != 0;
         default: return 0;
      endcase
   endfunction
   function automatic bit exp_rerr(int sz, int t);
      if (sz == 3) return (t & 1) != 0;
      if (sz == 4) return (t & 3) != 0;
      return 0;
   endfunction

   task automatic do_ld(bit fp, int base, bit du, int disp, int addr, int sz, int tgt);
      @(negedge clk);
      ld_req = 1; ld_fp = fp; ld_base_idx = IDXW'(base); ld_disp_use = du;
      ld_disp_idx = IDXW'(disp); ld_addr = AW'(addr); ld_size = 3'(sz);
      ld_tgt = IDXW'(tgt);
      #1 last_go = ld_go;
      @(negedge clk);
      ld_req = 0;
      last_ovf = ovf_err;
   endtask

   task automatic do_cm(bit clr, bit fp, bit all, int tgt, bit hi, bit lo);
      @(negedge clk);
      cm_req = 1; cm_clear_only = clr; cm_fp = fp; cm_all = all;
      cm_tgt = IDXW'(tgt); cm_hi_avail = hi; cm_lo_avail = lo;
      @(negedge clk);
      cm_req = 0;
      last_exc = cm_exc;
   endtask

   task automatic do_cfg(bit v, bit l, int n);
      @(negedge clk);
      cfg_we = 1; cfg_valid = v; cfg_log_en = l; cfg_count = NW'(n);
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic flag(bit fp, int idx, output logic f);
      fq_fp = fp; fq_idx = IDXW'(idx);
      #1 f = fq_flag;
   endtask

   task automatic rd(int s);
      rd_idx = EW'(s);
      #1;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic f;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R13 reset state
      check("R13 go", ld_go, 0);
      check("R13 exc", cm_exc, 0);
      check("R13 ovf", ovf_err, 0);
      for (int s = 0; s < NENT; s++) begin
         rd(s); check("R13 slot", rd_valid, 0);
      end
      flag(0, 0, f); check("R13 flag", f, 0);
      flag(1, 63, f); check("R13 flag", f, 0);

      // R1 / R2 sweep, logging off, clean sources 0 and 1
      for (int sz = 0; sz < 8; sz++)
         for (int a = 0; a < 16; a++)
            for (int t = 0; t < 4; t++) begin
               int tg = 8 + t + 4 * (a & 1);
               do_ld(0, 0, 0, 1, 'h1000 + a, sz, tg);
               check("R1 go", last_go, 1);
               flag(0, tg, f);
               check(exp_rerr(sz, tg) ? "R2 flag" : "R1 flag", f,
                     exp_mis(sz, a) | exp_rerr(sz, tg));
            end

      // R3 / R4 propagation
      do_ld(0, 0, 0, 0, 1, 1, 20);
      flag(0, 20, f); check("R1 poison", f, 1);
      do_ld(0, 20, 0, 0, 'h40, 2, 21);
      check("R3 base go", last_go, 0);
      flag(0, 21, f); check("R3 base flag", f, 1);
      do_ld(0, 0, 1, 20, 'h40, 2, 22);
      check("R3 disp go", last_go, 0);
      flag(0, 22, f); check("R3 disp flag", f, 1);
      do_ld(0, 0, 0, 20, 'h40, 2, 22);
      check("R4 disp unused go", last_go, 1);
      flag(0, 22, f); check("R4 flag cleared", f, 0);
      do_ld(0, 20, 0, 0, 'h42, 2, 23);
      check("R3 fault overrides go", last_go, 1);
      flag(0, 23, f); check("R3 fault flag", f, 1);
      // R14: same index in fp bank is clean
      do_ld(1, 20, 0, 0, 'h40, 2, 24);
      check("R14 fp clean go", last_go, 1);
      flag(1, 24, f); check("R14 fp flag", f, 0);
      flag(0, 20, f); check("R14 int kept", f, 1);

      // clean up int flags via clear-all (logging off)
      do_cm(1, 0, 1, 0, 1, 1);
      check("R10 no exc", last_exc, 0);
      flag(0, 20, f); check("R8 wiped", f, 0);

      // R5 logging
      do_cfg(1, 1, 3);
      do_ld(0, 0, 0, 0, 'h2002, 2, 10);
      do_ld(1, 0, 0, 0, 'h3000, 3, 11);
      do_ld(0, 0, 0, 0, 'h4001, 0, 12);
      check("R6 no ovf", last_ovf, 0);
      rd(0);
      check("R5 v", rd_valid, 1); check("R5 eav", rd_eav, 1);
      check("R5 fp", rd_fp, 0); check("R5 size", rd_size, 2);
      check("R5 tgt", rd_tgt, 10); check("R5 slot", rd_slot, 0);
      check("R5 me", rd_mem_err, 1); check("R5 re", rd_reg_err, 0);
      check("R5 addr", rd_addr, 'h2002);
      rd(1);
      check("R5 fp1", rd_fp, 1); check("R5 re1", rd_reg_err, 1);
      check("R5 me1", rd_mem_err, 0); check("R5 slot1", rd_slot, 1);
      rd(2); check("R5 slot2", rd_tgt, 12);
      rd(3); check("R5 limit", rd_valid, 0);
      do_ld(0, 0, 0, 0, 1, 1, 13);
      check("R6 ovf", last_ovf, 1);
      flag(0, 13, f); check("R6 flag still set", f, 1);
      @(negedge clk); check("R6 pulse ends", ovf_err, 0);

      // R7 / R9
      do_cm(0, 0, 0, 10, 1, 1);
      check("R7 exc", last_exc, 1);
      flag(0, 10, f); check("R7 cleared", f, 0);
      rd(0); check("R9 killed", rd_valid, 0);
      rd(1); check("R9 other bank", rd_valid, 1);
      do_ld(0, 0, 0, 0, 'h50, 0, 14);
      rd(0); check("R5 reuse lowest", rd_tgt, 14);
      do_cm(0, 0, 0, 12, 1, 1);
      check("R7 not pending", last_exc, 0);
      rd(2); check("R9 kept", rd_valid, 1);
      do_cm(1, 0, 0, 12, 1, 1);
      check("R10 exc", last_exc, 0);
      rd(2); check("R10 killed", rd_valid, 0);
      flag(1, 11, f); check("R10 pre", f, 1);
      do_cm(1, 1, 0, 11, 1, 1);
      check("R10 fp exc", last_exc, 0);
      flag(1, 11, f); check("R10 fp flag", f, 0);
      rd(1); check("R10 fp killed", rd_valid, 0);

      // R8 halves
      do_ld(0, 0, 0, 0, 1, 1, 40);
      do_ld(0, 0, 0, 0, 1, 1, 5);
      do_cm(0, 0, 1, 0, 1, 0);
      check("R8 exc", last_exc, 1);
      flag(0, 40, f); check("R8 hi cleared", f, 0);
      flag(0, 5, f); check("R8 lo kept", f, 1);
      flag(0, 13, f); check("R8 lo kept13", f, 1);
      rd(0); check("R9 all killed0", rd_valid, 0);
      rd(2); check("R9 all killed2", rd_valid, 0);
      do_cm(0, 0, 1, 0, 0, 0);
      check("R8 none avail", last_exc, 0);
      flag(0, 13, f); check("R8 none kept", f, 1);

      // R12
      do_cm(0, 0, 0, 13, 1, 0);
      check("R12 exc", last_exc, 0);
      flag(0, 13, f); check("R12 kept", f, 1);

      // R11
      do_ld(0, 0, 0, 0, 1, 1, 13);
      do_cfg(0, 1, 3);
      do_cm(0, 0, 0, 13, 1, 1);
      check("R11 exc", last_exc, 0);
      flag(0, 13, f); check("R11 cleared", f, 0);
      rd(0); check("R11 slot kept", rd_valid, 1);

      // R14 commit bank isolation
      do_ld(1, 0, 0, 0, 1, 1, 30);
      do_cm(0, 0, 1, 0, 1, 1);
      flag(1, 30, f); check("R14 fp untouched", f, 1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule